// File: doc/BRIEF.md
# Shared-Counter PWM Plus Rate-Multiplier DAC Generator

This block drives several single-bit outputs. Once each output is low-pass filtered off chip, it acts as a digital-to-analog converter with a coarse and a fine part. One free-running counter serves every channel. Its low six bits set a fixed 64-cycle pulse period. The next four bits number the periods inside a 16-period frame. Each channel holds a 10-bit code. The upper six bits give a pulse width in clock cycles. The lower four bits add single-cycle stretches to selected periods of the frame, so the average duty cycle over a frame resolves 1/1024 of full scale while the pulse frequency stays at clock/64.

Each channel has its own configuration: an enable, an inversion bit, and a direct mode in which the output shows a static level bit instead of the pulse train. A new code first goes into a holding register. It becomes active only when the period counter rolls over, so a running pulse is never cut short.

Top module: `pwm_brm_dac`

## Requirements
- R1: A 12-bit counter starts at 0 when reset is released and advances by one on every clock with no gating. Its bits 5:0 are the phase within a 64-cycle period and its bits 9:6 are the period index within a 16-period frame.
- R2: A channel code is 10 bits wide. Bits 9:4 are the width w (0 to 63) and bits 3:0 are the fraction f.
- R3: In pulse mode, with the channel enabled and not inverted, the output is high in the cycle that follows a counter phase p exactly when p < w + s. Here s is that period's stretch bit (0 or 1). The output therefore rises at the start of a period and falls once the width is reached.
- R4: For period index q, s is 0 when q = 0. Otherwise let j be the position of the lowest set bit of q; then s is bit (3 - j) of f. Over one frame, the number of high cycles is 16*w + f.
- R5: When w + s = 0 the output stays low for the whole period. When w + s = 64 it stays high for the whole period.
- R6: A code write goes into a holding register. The active code takes the held value only on the clock edge where the phase is 63. A write during a period has no effect on the rest of that period.
- R7: The inversion bit XORs the final output in every mode, including the disabled state.
- R8: In direct mode an enabled channel outputs its level bit (XOR inversion), whatever its code.
- R9: A disabled channel outputs its inactive level. This is the value of its inversion bit.
- R10: A configuration write (enable, inversion, direct, level) is captured on the clock edge where its strobe is high. It governs the output from the following cycle on.
- R11: A synchronous active-low reset clears the counter, the held and active codes, the enables and the inversion bits. While reset is held and after it is released, every output is low until the channel is configured and given a nonzero code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the shared counter advances on every rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| val_we_i | input | NUM_CH | Per-channel strobe that writes the holding register |
| val_i | input | NUM_CH*10 | Per-channel codes; channel n uses bits [n*10 +: 10] |
| cfg_we_i | input | NUM_CH | Per-channel strobe that writes the configuration bits |
| cfg_enable_i | input | NUM_CH | Enable bit per channel |
| cfg_invert_i | input | NUM_CH | Output inversion bit per channel |
| cfg_direct_i | input | NUM_CH | Direct-mode select per channel (1 = static level output) |
| cfg_level_i | input | NUM_CH | Static level per channel, used in direct mode |
| pwm_o | output | NUM_CH | Channel outputs |

## Verification
The bench sweeps the width through all 64 values and the fraction through all 16 values on four channels at once. Each period is compared against the arithmetic rule of R3 and R4. A wrong stretch selection would move or drop single cycles in specific periods, and a wrong frame total would show a biased average. The extreme codes (width 0 and width 64) catch an end-of-pulse match that fires at the same moment as the set and leaves a stray one-cycle pulse, or that never releases the output. Every new code is written in the middle of the last period of a frame. A design that skips the holding register would change that period's pulse width, and the check on that period would report it. The inversion, direct-mode, disable and reset cases each use a nonzero code, so a mux that ignores its select would show the pulse train where a constant level is expected.

// File: rtl/pwm_brm_pkg.sv
// Package: shared types for the shared-counter pulse/rate-multiplier DAC.
// Assumes: one configuration record per channel, updated as a whole.
package pwm_brm_pkg;

    // Per-channel configuration record
    typedef struct packed {
        logic enable;  // channel produces its waveform when set
        logic invert;  // XOR applied to the final output
        logic direct;  // static level instead of the pulse train
        logic level;   // static level used in direct mode
    } pwm_chan_cfg_t;

    localparam pwm_chan_cfg_t PWM_CFG_RESET = '{enable: 1'b0, invert: 1'b0,
                                                direct: 1'b0, level: 1'b0};

endpackage

// File: rtl/pwm_brm_counter.sv
// Module: free-running shared counter.
// Does:    advances by one on every clock. It also flags the cycle in which the
//          phase field (low PHASE_W bits) holds its last value, i.e. the edge at
//          which the next period begins.
// Assumes: CNT_W >= PHASE_W; synchronous active-low reset to zero.
module pwm_brm_counter #(
    parameter int CNT_W   = 12,
    parameter int PHASE_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] cnt_o,
    output logic             wrap_o
);

    logic [CNT_W-1:0] cnt_q;

    // Count every clock; clear on reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign cnt_o  = cnt_q;
    assign wrap_o = &cnt_q[PHASE_W-1:0];

endmodule

// File: rtl/pwm_brm_cfg_bank.sv
// Module: per-channel configuration registers.
// Does:    captures enable / invert / direct / level for a channel when that
//          channel's strobe is high, and presents them as flat vectors.
// Assumes: strobes are synchronous to clk; reset clears every record.
module pwm_brm_cfg_bank
    import pwm_brm_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] we_i,
    input  logic [NUM_CH-1:0] enable_i,
    input  logic [NUM_CH-1:0] invert_i,
    input  logic [NUM_CH-1:0] direct_i,
    input  logic [NUM_CH-1:0] level_i,
    output logic [NUM_CH-1:0] enable_o,
    output logic [NUM_CH-1:0] invert_o,
    output logic [NUM_CH-1:0] direct_o,
    output logic [NUM_CH-1:0] level_o
);

    generate
        for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
            pwm_chan_cfg_t cfg_q;

            // Load the record on its strobe; clear on reset
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    cfg_q <= PWM_CFG_RESET;
                end else if (we_i[ch]) begin
                    cfg_q <= '{enable: enable_i[ch], invert: invert_i[ch],
                               direct: direct_i[ch], level: level_i[ch]};
                end
            end

            assign enable_o[ch] = cfg_q.enable;
            assign invert_o[ch] = cfg_q.invert;
            assign direct_o[ch] = cfg_q.direct;
            assign level_o[ch]  = cfg_q.level;
        end
    endgenerate

endmodule

// File: rtl/pwm_brm_rate.sv
// Module: binary rate multiplier selector.
// Does:    for a period index q and a fraction f, returns whether this period
//          gets a one-cycle stretch. Bit (W-1-j) of f owns the periods whose
//          lowest set index bit is j, so the MSB of f covers half the periods,
//          the next bit a quarter, and so on. Index 0 is never chosen.
// Assumes: purely combinational; PERIOD_W >= 1.
module pwm_brm_rate #(
    parameter int PERIOD_W = 4
) (
    input  logic [PERIOD_W-1:0] period_i,
    input  logic [PERIOD_W-1:0] frac_i,
    output logic                stretch_o
);

    logic [PERIOD_W-1:0] slot;      // one-hot: position of lowest set index bit
    logic [PERIOD_W-1:0] frac_rev;  // fraction with its bit order reversed

    generate
        for (genvar j = 0; j < PERIOD_W; j++) begin : g_slot
            if (j == 0) begin : g_lsb
                assign slot[j] = period_i[0];
            end else begin : g_upper
                assign slot[j] = period_i[j] & ~(|period_i[j-1:0]);
            end
            assign frac_rev[j] = frac_i[PERIOD_W-1-j];
        end
    endgenerate

    assign stretch_o = |(slot & frac_rev);

endmodule

// File: rtl/pwm_brm_chan.sv
// Module: one DAC channel.
// Does:    holds a written code until the period boundary and then makes it
//          active. Drives a raw pulse that is set when the phase is zero and
//          cleared when the phase equals width + stretch. A width of the full
//          period never matches, so the pulse stays high.
// Assumes: phase_i/period_i come from the shared counter and wrap_i is high
//          in the last phase of each period.
module pwm_brm_chan #(
    parameter int PHASE_W  = 6,
    parameter int PERIOD_W = 4,
    localparam int VAL_W   = PHASE_W + PERIOD_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_i,
    input  logic [VAL_W-1:0]    val_i,
    input  logic                wrap_i,
    input  logic [PHASE_W-1:0]  phase_i,
    input  logic [PERIOD_W-1:0] period_i,
    output logic                raw_o,
    output logic [VAL_W-1:0]    act_o
);

    logic [VAL_W-1:0]    hold_q;
    logic [VAL_W-1:0]    act_q;
    logic                raw_q;
    logic [PHASE_W-1:0]  weight;
    logic [PERIOD_W-1:0] frac;
    logic                stretch;
    logic [PHASE_W:0]    width;
    logic                end_hit;
    logic                start_hit;

    // Holding register: take a new code whenever it is written
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else if (wr_i) begin
            hold_q <= val_i;
        end
    end

    // Active code: refresh only at the period boundary
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q <= '0;
        end else if (wrap_i) begin
            act_q <= hold_q;
        end
    end

    assign weight = act_q[VAL_W-1:PERIOD_W];
    assign frac   = act_q[PERIOD_W-1:0];

    pwm_brm_rate #(
        .PERIOD_W (PERIOD_W)
    ) u_rate (
        .period_i  (period_i),
        .frac_i    (frac),
        .stretch_o (stretch)
    );

    assign width     = {1'b0, weight} + {{PHASE_W{1'b0}}, stretch};
    assign end_hit   = !width[PHASE_W] && (phase_i == width[PHASE_W-1:0]);
    assign start_hit = (phase_i == '0);

    // Set/clear pulse flop: clear wins so a zero width stays low
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raw_q <= 1'b0;
        end else if (end_hit) begin
            raw_q <= 1'b0;
        end else if (start_hit) begin
            raw_q <= 1'b1;
        end
    end

    assign raw_o = raw_q;
    assign act_o = act_q;

endmodule

// File: rtl/pwm_brm_dac.sv
// Module: multi-channel shared-counter pulse/rate-multiplier DAC (top).
// Does:    one counter feeds NUM_CH channels. Each channel output is its raw
//          pulse, its static level, or idle, chosen by its configuration and
//          then XORed with its inversion bit.
// Assumes: CNT_W >= PHASE_W + PERIOD_W; synchronous active-low reset.
module pwm_brm_dac #(
    parameter int NUM_CH   = 4,
    parameter int PHASE_W  = 6,
    parameter int PERIOD_W = 4,
    parameter int CNT_W    = 12,
    localparam int VAL_W   = PHASE_W + PERIOD_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NUM_CH-1:0]       val_we_i,
    input  logic [NUM_CH*VAL_W-1:0] val_i,
    input  logic [NUM_CH-1:0]       cfg_we_i,
    input  logic [NUM_CH-1:0]       cfg_enable_i,
    input  logic [NUM_CH-1:0]       cfg_invert_i,
    input  logic [NUM_CH-1:0]       cfg_direct_i,
    input  logic [NUM_CH-1:0]       cfg_level_i,
    output logic [NUM_CH-1:0]       pwm_o
);

    logic [CNT_W-1:0]        cnt_q;
    logic                    wrap;
    logic [PHASE_W-1:0]      phase;
    logic [PERIOD_W-1:0]     period;
    logic [NUM_CH-1:0]       raw_vec;
    logic [NUM_CH*VAL_W-1:0] act_vec;
    logic [NUM_CH-1:0]       en_vec;
    logic [NUM_CH-1:0]       inv_vec;
    logic [NUM_CH-1:0]       dir_vec;
    logic [NUM_CH-1:0]       lvl_vec;

    pwm_brm_counter #(
        .CNT_W   (CNT_W),
        .PHASE_W (PHASE_W)
    ) u_counter (
        .clk    (clk),
        .rst_n  (rst_n),
        .cnt_o  (cnt_q),
        .wrap_o (wrap)
    );

    assign phase  = cnt_q[PHASE_W-1:0];
    assign period = cnt_q[PHASE_W+PERIOD_W-1:PHASE_W];

    pwm_brm_cfg_bank #(
        .NUM_CH (NUM_CH)
    ) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .we_i     (cfg_we_i),
        .enable_i (cfg_enable_i),
        .invert_i (cfg_invert_i),
        .direct_i (cfg_direct_i),
        .level_i  (cfg_level_i),
        .enable_o (en_vec),
        .invert_o (inv_vec),
        .direct_o (dir_vec),
        .level_o  (lvl_vec)
    );

    generate
        for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
            logic sel_level;

            pwm_brm_chan #(
                .PHASE_W  (PHASE_W),
                .PERIOD_W (PERIOD_W)
            ) u_chan (
                .clk      (clk),
                .rst_n    (rst_n),
                .wr_i     (val_we_i[ch]),
                .val_i    (val_i[ch*VAL_W +: VAL_W]),
                .wrap_i   (wrap),
                .phase_i  (phase),
                .period_i (period),
                .raw_o    (raw_vec[ch]),
                .act_o    (act_vec[ch*VAL_W +: VAL_W])
            );

            // Pick waveform source, then apply inversion
            always_comb begin
                if (!en_vec[ch]) begin
                    sel_level = 1'b0;
                end else if (dir_vec[ch]) begin
                    sel_level = lvl_vec[ch];
                end else begin
                    sel_level = raw_vec[ch];
                end
                pwm_o[ch] = sel_level ^ inv_vec[ch];
            end
        end
    endgenerate

endmodule

// File: rtl/pwm_brm_dac_chk.sv
// Module: property checker for pwm_brm_dac, attached by bind below.
// Does:    watches the shared counter, the per-channel raw pulses and active
//          codes, the configuration vectors and the outputs.
// Assumes: observation only; it drives nothing.
module pwm_brm_dac_chk #(
    parameter int NUM_CH   = 4,
    parameter int PHASE_W  = 6,
    parameter int PERIOD_W = 4,
    parameter int CNT_W    = 12,
    localparam int VAL_W   = PHASE_W + PERIOD_W
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [CNT_W-1:0]        cnt_q,
    input logic [NUM_CH-1:0]       raw_vec,
    input logic [NUM_CH*VAL_W-1:0] act_vec,
    input logic [NUM_CH-1:0]       en_vec,
    input logic [NUM_CH-1:0]       inv_vec,
    input logic [NUM_CH-1:0]       dir_vec,
    input logic [NUM_CH-1:0]       lvl_vec,
    input logic [NUM_CH-1:0]       pwm_o
);

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1))); // R1

    generate
        for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chk
            AST_ACT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
                (cnt_q[PHASE_W-1:0] != '0) |-> $stable(act_vec[ch*VAL_W +: VAL_W])); // R6

            AST_RISE_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(raw_vec[ch]) |-> (cnt_q[PHASE_W-1:0] == PHASE_W'(1))); // R3

            AST_DISABLED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
                !en_vec[ch] |-> (pwm_o[ch] == inv_vec[ch])); // R9

            AST_DIRECT_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
                (en_vec[ch] && dir_vec[ch]) |-> (pwm_o[ch] == (lvl_vec[ch] ^ inv_vec[ch]))); // R8
        end
    endgenerate

endmodule

bind pwm_brm_dac pwm_brm_dac_chk #(
    .NUM_CH   (NUM_CH),
    .PHASE_W  (PHASE_W),
    .PERIOD_W (PERIOD_W),
    .CNT_W    (CNT_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cnt_q   (cnt_q),
    .raw_vec (raw_vec),
    .act_vec (act_vec),
    .en_vec  (en_vec),
    .inv_vec (inv_vec),
    .dir_vec (dir_vec),
    .lvl_vec (lvl_vec),
    .pwm_o   (pwm_o)
);

// File: tb/pwm_brm_dac_bench.sv
// Bench: frame-by-frame sweep of codes and configurations on four channels.
// Expected levels come from the arithmetic rules in the requirements.
module pwm_brm_dac_bench;

    localparam int NUM_CH = 4;
    localparam int VAL_W  = 10;
    localparam int FRAME  = 1024;
    localparam int NF     = 67;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic [NUM_CH-1:0]       val_we_i = '0;
    logic [NUM_CH*VAL_W-1:0] val_i = '0;
    logic [NUM_CH-1:0]       cfg_we_i = '0;
    logic [NUM_CH-1:0]       cfg_enable_i = '0;
    logic [NUM_CH-1:0]       cfg_invert_i = '0;
    logic [NUM_CH-1:0]       cfg_direct_i = '0;
    logic [NUM_CH-1:0]       cfg_level_i = '0;
    logic [NUM_CH-1:0]       pwm_o;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pwm_brm_dac u_pwm_brm_dac (
        .clk          (clk),
        .rst_n        (rst_n),
        .val_we_i     (val_we_i),
        .val_i        (val_i),
        .cfg_we_i     (cfg_we_i),
        .cfg_enable_i (cfg_enable_i),
        .cfg_invert_i (cfg_invert_i),
        .cfg_direct_i (cfg_direct_i),
        .cfg_level_i  (cfg_level_i),
        .pwm_o        (pwm_o)
    );

    // Code active during frame f for channel ch: {width[9:4], fraction[3:0]}
    function automatic logic [9:0] val_for(int f, int ch);
        int i, w, b;
        if (f == 0) return 10'd0;
        if (f >= 65) begin
            case (ch)
                0: begin w = 63; b = 15; end
                1: begin w = 40; b = 9;  end
                2: begin w = 20; b = 3;  end
                default: begin w = 0; b = 0; end
            endcase
        end else begin
            i = f - 1;
            case (ch)
                0: begin w = i;                 b = i % 16;        end
                1: begin w = 63 - i;            b = 15 - (i % 16); end
                2: begin w = (i * 5 + 7) % 64;  b = (i * 3) % 16;  end
                default: begin w = (i * 11 + 3) % 64; b = (i * 7 + 1) % 16; end
            endcase
        end
        return {6'(w), 4'(b)};
    endfunction

    // Configuration during frame f: {enable, invert, direct, level}
    function automatic logic [3:0] cfg_for(int f, int ch);
        if (f == 0) return 4'b0000;
        if (f == 65) begin
            case (ch)
                0: return 4'b1100;
                1: return 4'b0000;
                2: return 4'b0100;
                default: return 4'b1011;
            endcase
        end
        if (f >= 66) begin
            case (ch)
                0: return 4'b1100;
                1: return 4'b1100;
                2: return 4'b1110;
                default: return 4'b1010;
            endcase
        end
        return 4'b1000;
    endfunction

    // Stretch bit for period q and fraction b (R4)
    function automatic int stretch_of(int q, int b);
        for (int j = 0; j < 4; j++) begin
            if (((q >> j) & 1) != 0) return (b >> (3 - j)) & 1;
        end
        return 0;
    endfunction

    function automatic string tag_for(int f, int ch, int q, int wid);
        logic [3:0] c;
        string t;
        c = cfg_for(f, ch);
        if (f == 0) return "R11";
        if (!c[3])      t = "R9";
        else if (c[1])  t = "R8";
        else begin
            t = "R3 R1 R2";
            if (wid == 0 || wid == 64) t = {t, " R5"};
            if (q == 15) t = {t, " R6"};
        end
        if (c[2]) t = {t, " R7"};
        if (f >= 65) t = {t, " R10"};
        return t;
    endfunction

    task automatic chk(bit ok, string tag, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R1 watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int mism [NUM_CH];
        int ha   [NUM_CH];
        int he   [NUM_CH];
        int fr   [NUM_CH];

        // Reset held: outputs low (R11)
        for (int r = 0; r < 3; r++) begin
            step();
            chk(pwm_o == '0, "R11", "outputs during reset", int'(pwm_o), 0);
        end
        rst_n = 1'b1;

        for (int f = 0; f < NF; f++) begin
            for (int ch = 0; ch < NUM_CH; ch++) begin
                mism[ch] = 0; ha[ch] = 0; he[ch] = 0; fr[ch] = 0;
            end
            for (int c = 0; c < FRAME; c++) begin
                int q, pos;
                step();
                q   = c / 64;
                pos = c % 64;
                for (int ch = 0; ch < NUM_CH; ch++) begin
                    logic [9:0] v;
                    logic [3:0] cf;
                    int wid;
                    bit rawe, e, a;
                    v   = val_for(f, ch);
                    cf  = cfg_for(f, ch);
                    wid = int'(v[9:4]) + stretch_of(q, int'(v[3:0]));
                    rawe = (pos < wid);
                    e = (cf[3] ? (cf[1] ? cf[0] : rawe) : 1'b0) ^ cf[2];
                    a = pwm_o[ch];
                    if (a != e) mism[ch]++;
                    ha[ch] += int'(a);
                    he[ch] += int'(e);
                    fr[ch] += int'(a ^ cf[2]);
                    if (pos == 63) begin
                        chk(mism[ch] == 0, tag_for(f, ch, q, wid),
                            $sformatf("ch%0d frame %0d period %0d high cycles (mismatches %0d)",
                                      ch, f, q, mism[ch]), ha[ch], he[ch]);
                        mism[ch] = 0; ha[ch] = 0; he[ch] = 0;
                    end
                end
                // Configuration strobe released after one edge
                if (c == 0) cfg_we_i = '0;
                // Next code written mid-period in the last period (R6)
                if (c == 1000) begin
                    for (int ch = 0; ch < NUM_CH; ch++)
                        val_i[ch*VAL_W +: VAL_W] = val_for(f + 1, ch);
                    val_we_i = '1;
                end
                if (c == 1001) val_we_i = '0;
                // Next configuration lands on the frame boundary (R10)
                if (c == FRAME - 1) begin
                    for (int ch = 0; ch < NUM_CH; ch++) begin
                        logic [3:0] nc;
                        nc = cfg_for(f + 1, ch);
                        cfg_enable_i[ch] = nc[3];
                        cfg_invert_i[ch] = nc[2];
                        cfg_direct_i[ch] = nc[1];
                        cfg_level_i[ch]  = nc[0];
                    end
                    cfg_we_i = '1;
                end
            end
            // Frame total equals 16*w + f (R4)
            for (int ch = 0; ch < NUM_CH; ch++) begin
                logic [3:0] cf;
                logic [9:0] v;
                cf = cfg_for(f, ch);
                v  = val_for(f, ch);
                if (f > 0 && cf[3] && !cf[1])
                    chk(fr[ch] == 16 * int'(v[9:4]) + int'(v[3:0]), "R4",
                        $sformatf("ch%0d frame %0d total high cycles", ch, f),
                        fr[ch], 16 * int'(v[9:4]) + int'(v[3:0]));
            end
        end

        // Second reset: inversion, config and codes all cleared (R11)
        cfg_we_i = '0;
        rst_n = 1'b0;
        for (int r = 0; r < 3; r++) begin
            step();
            chk(pwm_o == '0, "R11", "outputs during second reset", int'(pwm_o), 0);
        end
        rst_n = 1'b1;
        cfg_enable_i = '1;
        cfg_invert_i = '0;
        cfg_direct_i = '0;
        cfg_level_i  = '0;
        cfg_we_i = '1;
        step();
        cfg_we_i = '0;
        for (int r = 0; r < 200; r++) begin
            step();
            chk(pwm_o == '0, "R11", $sformatf("enabled outputs with cleared codes, cycle %0d", r),
                int'(pwm_o), 0);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule